// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Processor Core

This core runs one instruction to completion in every clock cycle. On each cycle it reads the word at the program counter from a private instruction store, splits it into fields, reads two source registers, computes through a single ALU and then commits at the next rising edge. That commit updates the program counter and, when the instruction calls for it, either one register or one data memory word. The supported set is register add, subtract, AND, OR and signed set-less-than, plus load word, store word, branch-if-equal and an absolute jump.

Decoding runs in two levels. The opcode selects a 2-bit ALU class: add for memory access, subtract for branch compare, or "look at the function field" for register operations. The class and the function field together then give a 3-bit ALU command, made of an invert-B bit and a 2-bit operation select. Instruction and data memories are separate word arrays inside the core, filled by the surrounding environment before reset is released. The only inputs are clock and synchronous reset. A debug port shows the current PC and the register write-back that the current instruction will commit at the next edge.

Top module: `sc_cpu`

## Requirements
- R1: While reset is high at a rising edge the PC becomes 0 and all 32 registers become 0. After reset the first instruction executed is the one at byte address 0.
- R2: The PC is always word aligned. When no branch is taken and no jump executes, the PC at the next edge is the current PC plus 4.
- R3: Opcode 000000 is a register operation writing rd (bits 15-11) from rs (bits 25-21) and rt (bits 20-16). Function field (bits 5-0) 100000 selects add, 100010 subtract, 100100 AND, 100101 OR and 101010 set-less-than.
- R4: Set-less-than compares signed two's-complement values and writes 1 when rs is less than rt, otherwise 0.
- R5: Opcode 100011 loads into rt the data word at address rs plus the sign-extended 16-bit offset (bits 15-0). Negative offsets are allowed.
- R6: Opcode 101011 writes rt to the data word at rs plus the sign-extended offset at the next edge, and writes no register.
- R7: Opcode 000100 compares rs and rt. When they are equal the next PC is PC+4 plus the sign-extended offset shifted left by 2, which may be negative. Otherwise the next PC is PC+4. The instruction writes neither registers nor memory.
- R8: Opcode 000010 sets the next PC to the upper 4 bits of PC+4, followed by instruction bits 25-0, followed by two zero bits.
- R9: Register 0 always reads as zero. A write aimed at it is dropped and is not reported on the debug write-back port.
- R10: Any opcode other than the five above acts as a no-op: no register write, no memory write, and the PC advances by 4.
- R11: The debug port shows the PC of the instruction now executing, together with the enable, register number and data of the write that instruction commits at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wb_en | output | 1 | High when this instruction writes a nonzero register |
| dbg_wb_addr | output | 5 | Destination register number |
| dbg_wb_data | output | 32 | Value written to the destination register |

## Verification
Every result of this core belongs to the cycle in which its instruction is current. The write-back fields on the debug port are combinational from the instruction at dbg_pc. The effect of a commit shows up one edge later: as the next PC, or as a register or memory value read back by a later instruction. The bench releases reset on a falling edge, which makes the instruction at address 0 current at once. It then compares the whole debug port one time unit after each following falling edge, checking the exact PC sequence that branches and jumps must produce. Stores are confirmed by a later load through the write-back port.

// File: rtl/sc_cpu.sv
module sc_cpu #(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_wb_en,
  output logic [4:0]  dbg_wb_addr,
  output logic [31:0] dbg_wb_data
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);

  localparam logic [5:0] OP_REG = 6'b000000;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_J   = 6'b000010;

  logic [31:0] imem [IMEM_DEPTH];
  logic [31:0] dmem [DMEM_DEPTH];
  logic [31:0] rf   [32];

  initial begin
    for (int i = 0; i < IMEM_DEPTH; i++) imem[i] = '0;
  end

  logic [31:0] pc, pc4, instr;
  assign instr = imem[pc[IAW+1:2]];
  assign pc4   = pc + 32'd4;

  logic [5:0] op, fn;
  logic [4:0] rs, rt, rd, dest;
  logic [31:0] imm_sx;
  assign op     = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign fn     = instr[5:0];
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  logic reg_dst, alu_src, mem_to_reg, reg_write, mem_write, branch, jump;
  logic [1:0] alu_class;

  always_comb begin
    {reg_dst, alu_src, mem_to_reg, reg_write, mem_write, branch, jump} = '0;
    alu_class = 2'b00;
    case (op)
      OP_REG: begin reg_dst = 1'b1; reg_write = 1'b1; alu_class = 2'b10; end
      OP_LW:  begin alu_src = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1; end
      OP_SW:  begin alu_src = 1'b1; mem_write = 1'b1; end
      OP_BEQ: begin branch = 1'b1; alu_class = 2'b01; end
      OP_J:   jump = 1'b1;
      default: ;
    endcase
  end

  logic [2:0] alu_cmd;
  always_comb begin
    case (alu_class)
      2'b00:   alu_cmd = 3'b010;
      2'b01:   alu_cmd = 3'b110;
      default: case (fn)
        6'b100010: alu_cmd = 3'b110;
        6'b100100: alu_cmd = 3'b000;
        6'b100101: alu_cmd = 3'b001;
        6'b101010: alu_cmd = 3'b111;
        default:   alu_cmd = 3'b010;
      endcase
    endcase
  end

  logic [31:0] rs_val, rt_val, alu_a, alu_b, b_eff, sum, alu_y, wb_val;
  logic        less, alu_zero;
  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_a  = rs_val;
  assign alu_b  = alu_src ? imm_sx : rt_val;
  assign b_eff  = alu_cmd[2] ? ~alu_b : alu_b;
  assign sum    = alu_a + b_eff + {31'd0, alu_cmd[2]};
  assign less   = (alu_a[31] ^ alu_b[31]) ? alu_a[31] : sum[31];

  always_comb begin
    case (alu_cmd[1:0])
      2'b00:   alu_y = alu_a & alu_b;
      2'b01:   alu_y = alu_a | alu_b;
      2'b10:   alu_y = sum;
      default: alu_y = {31'd0, less};
    endcase
  end
  assign alu_zero = (alu_y == 32'd0);

  logic [DAW-1:0] d_idx;
  assign d_idx  = alu_y[DAW+1:2];
  assign wb_val = mem_to_reg ? dmem[d_idx] : alu_y;
  assign dest   = reg_dst ? rd : rt;

  logic        take_br;
  logic [31:0] br_tgt, j_tgt, pc_nxt;
  assign take_br = branch & alu_zero;
  assign br_tgt  = pc4 + {imm_sx[29:0], 2'b00};
  assign j_tgt   = {pc4[31:28], instr[25:0], 2'b00};
  assign pc_nxt  = jump ? j_tgt : (take_br ? br_tgt : pc4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      pc <= pc_nxt;
      if (reg_write && dest != 5'd0) rf[dest] <= wb_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && mem_write) dmem[d_idx] <= rt_val;
  end

  assign dbg_pc      = pc;
  assign dbg_wb_en   = reg_write && (dest != 5'd0);
  assign dbg_wb_addr = dest;
  assign dbg_wb_data = wb_val;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) dbg_pc[1:0] == 2'b00); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!jump && !(branch && rs_val == rt_val)) |=> dbg_pc == $past(dbg_pc) + 32'd4); // R2
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val == rt_val) |=> dbg_pc == $past(dbg_pc) + 32'd4 + ($past(imm_sx) << 2)); // R7
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (op == OP_J) |=> dbg_pc[31:28] == $past(pc4[31:28])); // R8
  AST_STORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SW) |-> !dbg_wb_en); // R6
  AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_write, reg_write, branch, jump})); // R10
  AST_R0_HOLDS: assert property (@(posedge clk) disable iff (rst) rf[0] == 32'd0); // R9
endmodule

// File: tb/sc_cpu_bench.sv
module sc_cpu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wb_en;
  logic [4:0]  dbg_wb_addr;
  logic [31:0] dbg_wb_data;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_cpu u_sc_cpu (.clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wb_en(dbg_wb_en),
                   .dbg_wb_addr(dbg_wb_addr), .dbg_wb_data(dbg_wb_data));

  function automatic logic [31:0] rtyp(input int s, input int t, input int d, input logic [5:0] f);
    return {6'b000000, s[4:0], t[4:0], d[4:0], 5'd0, f};
  endfunction
  function automatic logic [31:0] ityp(input logic [5:0] o, input int s, input int t, input int imm);
    return {o, s[4:0], t[4:0], imm[15:0]};
  endfunction

  task automatic expect_now(input string tag, input logic [31:0] pc, input logic en,
                            input logic [4:0] a, input logic [31:0] d);
    n_chk++;
    if (dbg_pc !== pc || dbg_wb_en !== en || (en && (dbg_wb_addr !== a || dbg_wb_data !== d))) begin
      n_bad++;
      $display("FAIL %s: got pc=%h en=%b r%0d=%h, expected pc=%h en=%b r%0d=%h",
               tag, dbg_pc, dbg_wb_en, dbg_wb_addr, dbg_wb_data, pc, en, a, d);
    end
  endtask

  task automatic step(input string tag, input logic [31:0] pc, input logic en,
                      input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    expect_now(tag, pc, en, a, d);
  endtask

  task automatic load_program();
    u_sc_cpu.dmem[0] = 32'd5;
    u_sc_cpu.dmem[1] = 32'hFFFF_FFFD;
    u_sc_cpu.dmem[2] = 32'd12;
    u_sc_cpu.dmem[3] = 32'h0000_0F0F;
    u_sc_cpu.imem[0]  = ityp(6'b100011, 0, 1, 0);
    u_sc_cpu.imem[1]  = ityp(6'b100011, 0, 2, 4);
    u_sc_cpu.imem[2]  = ityp(6'b100011, 0, 3, 8);
    u_sc_cpu.imem[3]  = ityp(6'b100011, 0, 4, 12);
    u_sc_cpu.imem[4]  = rtyp(1, 2, 5, 6'b100000);
    u_sc_cpu.imem[5]  = rtyp(1, 2, 6, 6'b100010);
    u_sc_cpu.imem[6]  = rtyp(3, 4, 7, 6'b100100);
    u_sc_cpu.imem[7]  = rtyp(3, 4, 8, 6'b100101);
    u_sc_cpu.imem[8]  = rtyp(2, 1, 9, 6'b101010);
    u_sc_cpu.imem[9]  = rtyp(1, 2, 10, 6'b101010);
    u_sc_cpu.imem[10] = rtyp(1, 1, 0, 6'b100000);
    u_sc_cpu.imem[11] = rtyp(0, 0, 11, 6'b100000);
    u_sc_cpu.imem[12] = ityp(6'b101011, 3, 5, 16);
    u_sc_cpu.imem[13] = ityp(6'b100011, 0, 12, 28);
    u_sc_cpu.imem[14] = ityp(6'b100011, 3, 13, -4);
    u_sc_cpu.imem[15] = ityp(6'b000100, 1, 2, 5);
    u_sc_cpu.imem[16] = ityp(6'b000100, 3, 13, 2);
    u_sc_cpu.imem[17] = rtyp(1, 1, 14, 6'b100000);
    u_sc_cpu.imem[18] = rtyp(1, 1, 14, 6'b100000);
    u_sc_cpu.imem[19] = {6'b111111, 5'd1, 5'd15, 16'd0};
    u_sc_cpu.imem[20] = {6'b000010, 26'd25};
    for (int i = 21; i < 25; i++) u_sc_cpu.imem[i] = rtyp(1, 1, 15, 6'b100000);
    u_sc_cpu.imem[25] = ityp(6'b000100, 0, 0, -1);
  endtask

  task automatic t_reset_start();
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    expect_now("R1 reset pc, R5 first load", 32'd0, 1'b1, 5'd1, 32'd5);
  endtask

  task automatic t_alu();
    step("R5 load r2",  32'd4,  1'b1, 5'd2, 32'hFFFF_FFFD);
    step("R5 load r3",  32'd8,  1'b1, 5'd3, 32'd12);
    step("R5 load r4",  32'd12, 1'b1, 5'd4, 32'h0F0F);
    step("R3 add",      32'd16, 1'b1, 5'd5, 32'd2);
    step("R3 sub",      32'd20, 1'b1, 5'd6, 32'd8);
    step("R3 and",      32'd24, 1'b1, 5'd7, 32'h0C);
    step("R3 or",       32'd28, 1'b1, 5'd8, 32'h0F0F);
    step("R4 slt neg<pos", 32'd32, 1'b1, 5'd9, 32'd1);
    step("R4 slt pos<neg", 32'd36, 1'b1, 5'd10, 32'd0);
    step("R9 write r0 hidden", 32'd40, 1'b0, 5'd0, 32'd0);
    step("R9 r0 reads zero", 32'd44, 1'b1, 5'd11, 32'd0);
  endtask

  task automatic t_mem();
    step("R6 store no wb", 32'd48, 1'b0, 5'd0, 32'd0);
    step("R6 store landed", 32'd52, 1'b1, 5'd12, 32'd2);
    step("R5 negative offset", 32'd56, 1'b1, 5'd13, 32'd12);
  endtask

  task automatic t_flow();
    step("R7 beq not taken", 32'd60, 1'b0, 5'd0, 32'd0);
    step("R2 step after untaken", 32'd64, 1'b0, 5'd0, 32'd0);
    step("R7 beq taken target", 32'd76, 1'b0, 5'd0, 32'd0);
    step("R10 undefined op", 32'd80, 1'b0, 5'd0, 32'd0);
    step("R8 jump target", 32'd100, 1'b0, 5'd0, 32'd0);
    step("R7 backward branch", 32'd100, 1'b0, 5'd0, 32'd0);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    u_sc_cpu.imem[0] = rtyp(1, 2, 15, 6'b100101);
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    expect_now("R1 registers cleared", 32'd0, 1'b1, 5'd15, 32'd0);
    step("R11 pc after reset", 32'd4, 1'b1, 5'd2, 32'hFFFF_FFFD);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    load_program();
    t_reset_start();
    t_alu();
    t_mem();
    t_flow();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule